// File: doc/BRIEF.md
# Core Power-Up Release Sequencer

This block brings one secondary processor core out of power-off after a cold boot. A single start pulse begins the sequence. The block first sends a supply controller a rail-voltage command, a code value together with a one-cycle write strobe, and waits for the rail to settle. It then steps a live power-control word through clamp, cache-sleep and power-on-reset phases. Each phase holds for a fixed minimum time. At the end the block sets the core's powered-up bit and leaves it set.

Every minimum time is given in nanoseconds and converted to clock cycles from a clock-frequency parameter. The conversion rounds up, so no phase is ever shorter than its minimum. The release runs only once per cold boot. While the done flag is set, a new start request is answered at once with no new activity. Only a synchronous reset rearms the block.

Top module: `core_wake_seq`

## Requirements
- R1: While synchronous reset is high, and in the cycle after it, the control word is 0x000, the rail command is 0x00, and the rail strobe, busy and done are all low.
- R2: A start pulse seen while idle with done low makes the next cycle the first busy cycle. In that cycle the rail strobe is high for exactly one cycle and the rail command becomes 0xA4, which it then holds.
- R3: Control word bit positions are: bit 8 PLL clamp, bit 7 powered up, bit 5 power-on reset, bit 4 core reset, bit 3 cache data/tag sleep, bit 0 I/O clamp. Exactly ceil(512 us × CLK_HZ) cycles after the rail strobe cycle, the word becomes 0x109 (PLL clamp, cache sleep and I/O clamp together).
- R4: One cycle after the 0x109 step, only the cache sleep bit drops, giving 0x101.
- R5: Exactly ceil(300 ns × CLK_HZ) cycles after the 0x101 step, the power-on reset bit rises, giving 0x121.
- R6: Exactly ceil(2 us × CLK_HZ) cycles after the 0x121 step, the I/O clamp bit clears, giving 0x120.
- R7: Exactly ceil(2 us × CLK_HZ) cycles after the 0x120 step, the power-on reset bit clears, giving 0x100.
- R8: Exactly ceil(100 us × CLK_HZ) cycles after the 0x100 step, the powered-up bit is set, giving 0x180. In that same cycle done goes high and busy goes low. Word and done then hold until reset.
- R9: A start pulse while done is high produces no rail strobe and no busy cycle, and leaves the word and the rail command unchanged.
- R10: Start requests while busy are ignored. The sequence timing is unchanged, whether start is a pulse or is held high.
- R11: Once the sequence begins, the PLL clamp bit stays set whenever the word is nonzero. The core reset bit is never set.
- R12: Each phase length is the ceiling of its minimum time multiplied by CLK_HZ, with a floor of one cycle. At 100 MHz the lengths are 51200, 30, 200, 200 and 10000 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Release request |
| ctrlWord | output | 9 | Live core power-control word |
| railCmd | output | 8 | Rail-voltage command value |
| railStb | output | 1 | One-cycle write strobe for railCmd |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Core released; sticky until reset |

## Verification
The rail strobe and the command value are due one cycle after an accepted start. The first word step comes 51200 cycles after that. Each later step comes after its own rounded-up phase length, and done rises in the same cycle as the final word. A behavioural reference in the bench counts the edges since the accepted start and derives all expected outputs from these phase lengths. The bench compares the outputs three time units after every rising edge, once the registers have settled. Ignored requests, both mid-run and after done, are checked at the same points: the expected timeline must stay unchanged.

// File: rtl/core_wake_pkg.sv
package core_wake_pkg;

  localparam int CW_W         = 9;
  localparam int BIT_IOCLAMP  = 0;
  localparam int BIT_L2SLEEP  = 3;
  localparam int BIT_CORERST  = 4;
  localparam int BIT_POR      = 5;
  localparam int BIT_PWRUP    = 7;
  localparam int BIT_PLLCLAMP = 8;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_CLAMP_ALL,
    OP_DROP_L2,
    OP_SET_POR,
    OP_DROP_CLAMP,
    OP_DROP_POR,
    OP_PWRUP
  } word_op_e;

  typedef enum logic [2:0] {
    DLY_RAIL,
    DLY_ONE,
    DLY_PRE,
    DLY_POR,
    DLY_UNCL,
    DLY_SETTLE
  } dly_sel_e;

  typedef struct packed {
    logic     issueRail;
    logic     loadDelay;
    dly_sel_e dlySel;
    word_op_e wordOp;
  } seq_strb_t;

  // Rounds up so a phase never runs shorter than its minimum; at least one cycle.
  function automatic longint nsToCycles(input longint ns, input longint hz);
    longint c;
    c = (ns * hz + 64'd999_999_999) / 64'd1_000_000_000;
    if (c < 1) c = 1;
    return c;
  endfunction

endpackage

// File: rtl/core_wake_ctrl.sv
module core_wake_ctrl
  import core_wake_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      start,
  input  logic      cntLast,
  input  logic      doneFlag,
  output seq_strb_t strb,
  output logic      busy
);

  typedef enum logic [2:0] {
    S_IDLE,
    S_RAIL,
    S_L2,
    S_PRE,
    S_POR,
    S_UNCL,
    S_SETTLE
  } seq_state_e;

  seq_state_e state, stateNext;

  always_comb begin
    stateNext      = state;
    strb.issueRail = 1'b0;
    strb.loadDelay = 1'b0;
    strb.dlySel    = DLY_ONE;
    strb.wordOp    = OP_NONE;
    unique case (state)
      S_IDLE: begin
        if (start && !doneFlag) begin
          stateNext      = S_RAIL;
          strb.issueRail = 1'b1;
          strb.loadDelay = 1'b1;
          strb.dlySel    = DLY_RAIL;
        end
      end
      S_RAIL: begin
        if (cntLast) begin
          stateNext      = S_L2;
          strb.wordOp    = OP_CLAMP_ALL;
          strb.loadDelay = 1'b1;
          strb.dlySel    = DLY_ONE;
        end
      end
      S_L2: begin
        if (cntLast) begin
          stateNext      = S_PRE;
          strb.wordOp    = OP_DROP_L2;
          strb.loadDelay = 1'b1;
          strb.dlySel    = DLY_PRE;
        end
      end
      S_PRE: begin
        if (cntLast) begin
          stateNext      = S_POR;
          strb.wordOp    = OP_SET_POR;
          strb.loadDelay = 1'b1;
          strb.dlySel    = DLY_POR;
        end
      end
      S_POR: begin
        if (cntLast) begin
          stateNext      = S_UNCL;
          strb.wordOp    = OP_DROP_CLAMP;
          strb.loadDelay = 1'b1;
          strb.dlySel    = DLY_UNCL;
        end
      end
      S_UNCL: begin
        if (cntLast) begin
          stateNext      = S_SETTLE;
          strb.wordOp    = OP_DROP_POR;
          strb.loadDelay = 1'b1;
          strb.dlySel    = DLY_SETTLE;
        end
      end
      S_SETTLE: begin
        if (cntLast) begin
          stateNext   = S_IDLE;
          strb.wordOp = OP_PWRUP;
        end
      end
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= S_IDLE;
    else     state <= stateNext;
  end

  assign busy = (state != S_IDLE);

  // R2: an accepted request moves the sequence into its rail phase
  a_r2_accept: assert property (@(posedge clk) disable iff (rst)
    (state == S_IDLE && start && !doneFlag) |=> (state == S_RAIL));

  // R9: a finished release never restarts
  a_r9_skip_when_done: assert property (@(posedge clk) disable iff (rst)
    (state == S_IDLE && doneFlag) |=> (state == S_IDLE));

  // R10: a running phase only advances when its count expires
  a_r10_hold_phase: assert property (@(posedge clk) disable iff (rst)
    (state != S_IDLE && !cntLast) |=> (state == $past(state)));

endmodule

// File: rtl/core_wake_dp.sv
module core_wake_dp
  import core_wake_pkg::*;
#(
  parameter longint CLK_HZ     = 100_000_000,
  parameter int     RAIL_W     = 8,
  parameter logic [RAIL_W-1:0] RAIL_CODE = 8'hA4,
  parameter longint RAIL_NS    = 512_000,
  parameter longint PRE_NS     = 300,
  parameter longint POR_NS     = 2_000,
  parameter longint UNCL_NS    = 2_000,
  parameter longint SETTLE_NS  = 100_000
)(
  input  logic              clk,
  input  logic              rst,
  input  seq_strb_t         strb,
  output logic [CW_W-1:0]   ctrlWord,
  output logic [RAIL_W-1:0] railCmd,
  output logic              railStb,
  output logic              cntLast,
  output logic              doneFlag
);

  localparam longint N_RAIL   = nsToCycles(RAIL_NS, CLK_HZ);
  localparam longint N_PRE    = nsToCycles(PRE_NS, CLK_HZ);
  localparam longint N_POR    = nsToCycles(POR_NS, CLK_HZ);
  localparam longint N_UNCL   = nsToCycles(UNCL_NS, CLK_HZ);
  localparam longint N_SETTLE = nsToCycles(SETTLE_NS, CLK_HZ);
  localparam longint M_A      = (N_RAIL > N_SETTLE) ? N_RAIL : N_SETTLE;
  localparam longint M_B      = (N_POR > N_UNCL) ? N_POR : N_UNCL;
  localparam longint M_C      = (M_B > N_PRE) ? M_B : N_PRE;
  localparam longint N_MAX    = (M_A > M_C) ? M_A : M_C;
  localparam int     CNT_W    = $clog2(N_MAX + 1);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] dlyVal;

  always_comb begin
    unique case (strb.dlySel)
      DLY_RAIL:   dlyVal = CNT_W'(N_RAIL);
      DLY_PRE:    dlyVal = CNT_W'(N_PRE);
      DLY_POR:    dlyVal = CNT_W'(N_POR);
      DLY_UNCL:   dlyVal = CNT_W'(N_UNCL);
      DLY_SETTLE: dlyVal = CNT_W'(N_SETTLE);
      default:    dlyVal = CNT_W'(1);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)                 cnt <= '0;
    else if (strb.loadDelay) cnt <= dlyVal;
    else if (cnt != '0)      cnt <= cnt - 1'b1;
  end

  assign cntLast = (cnt == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      railCmd <= '0;
      railStb <= 1'b0;
    end else begin
      railStb <= strb.issueRail;
      if (strb.issueRail) railCmd <= RAIL_CODE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrlWord <= '0;
      doneFlag <= 1'b0;
    end else begin
      unique case (strb.wordOp)
        OP_CLAMP_ALL: begin
          ctrlWord[BIT_PLLCLAMP] <= 1'b1;
          ctrlWord[BIT_L2SLEEP]  <= 1'b1;
          ctrlWord[BIT_IOCLAMP]  <= 1'b1;
        end
        OP_DROP_L2:    ctrlWord[BIT_L2SLEEP] <= 1'b0;
        OP_SET_POR:    ctrlWord[BIT_POR]     <= 1'b1;
        OP_DROP_CLAMP: ctrlWord[BIT_IOCLAMP] <= 1'b0;
        OP_DROP_POR:   ctrlWord[BIT_POR]     <= 1'b0;
        OP_PWRUP: begin
          ctrlWord[BIT_PWRUP] <= 1'b1;
          doneFlag            <= 1'b1;
        end
        default: ;
      endcase
    end
  end

  // R2: the rail write strobe is a single-cycle pulse
  a_r2_strobe_pulse: assert property (@(posedge clk) disable iff (rst)
    railStb |=> !railStb);

  // R10: a rail command is only issued from a fully powered-off word
  a_r10_rail_only_cold: assert property (@(posedge clk) disable iff (rst)
    railStb |-> (ctrlWord == '0));

  // R11: PLL clamp accompanies every nonzero word; core reset never used
  a_r11_pll_held: assert property (@(posedge clk) disable iff (rst)
    (ctrlWord != '0) |-> ctrlWord[BIT_PLLCLAMP]);
  a_r11_no_core_rst: assert property (@(posedge clk) disable iff (rst)
    !ctrlWord[BIT_CORERST]);

  // R8: done and the final word are sticky
  a_r8_done_sticky: assert property (@(posedge clk) disable iff (rst)
    doneFlag |=> (doneFlag && $stable(ctrlWord)));

  // R12: the phase counter never exceeds the longest phase
  a_r12_cnt_bounded: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNT_W'(N_MAX));

endmodule

// File: rtl/core_wake_seq.sv
module core_wake_seq
  import core_wake_pkg::*;
#(
  parameter longint CLK_HZ = 100_000_000,
  parameter int     RAIL_W = 8,
  parameter logic [RAIL_W-1:0] RAIL_CODE = 8'hA4
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  output logic [CW_W-1:0]   ctrlWord,
  output logic [RAIL_W-1:0] railCmd,
  output logic              railStb,
  output logic              busy,
  output logic              done
);

  seq_strb_t strb;
  logic      cntLast;

  core_wake_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .cntLast  (cntLast),
    .doneFlag (done),
    .strb     (strb),
    .busy     (busy)
  );

  core_wake_dp #(
    .CLK_HZ    (CLK_HZ),
    .RAIL_W    (RAIL_W),
    .RAIL_CODE (RAIL_CODE)
  ) u_dp (
    .clk      (clk),
    .rst      (rst),
    .strb     (strb),
    .ctrlWord (ctrlWord),
    .railCmd  (railCmd),
    .railStb  (railStb),
    .cntLast  (cntLast),
    .doneFlag (done)
  );

endmodule

// File: tb/core_wake_seq_test.sv
module core_wake_seq_test;

  logic       clk = 1'b0;
  logic       rst;
  logic       start;
  logic [8:0] ctrlWord;
  logic [7:0] railCmd;
  logic       railStb;
  logic       busy;
  logic       done;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  core_wake_seq uut (
    .clk(clk), .rst(rst), .start(start), .ctrlWord(ctrlWord),
    .railCmd(railCmd), .railStb(railStb), .busy(busy), .done(done)
  );

  // R12: phase lengths at 100 MHz, rounded up from the minimum times
  localparam int NR = 51200;
  localparam int NP = 30;
  localparam int N2 = 200;
  localparam int NS = 10000;
  localparam int B1 = 1 + NR;
  localparam int B2 = B1 + 1;
  localparam int B3 = B2 + NP;
  localparam int B4 = B3 + N2;
  localparam int B5 = B4 + N2;
  localparam int B6 = B5 + NS;

  function automatic logic [8:0] wordAt(input int k);
    if (k >= B6) return 9'h180;
    if (k >= B5) return 9'h100;
    if (k >= B4) return 9'h120;
    if (k >= B3) return 9'h121;
    if (k >= B2) return 9'h101;
    if (k >= B1) return 9'h109;
    return 9'h000;
  endfunction

  function automatic string wordTag(input int k);
    if (k >= B6) return "R8";
    if (k >= B5) return "R7";
    if (k >= B4) return "R6";
    if (k >= B3) return "R5";
    if (k >= B2) return "R4";
    return "R3";
  endfunction

  // behavioural reference
  bit         mActive = 0;
  int         mK = 0;
  bit         mDone = 0;
  logic [8:0] mWord = '0;
  logic [7:0] mRail = '0;

  always @(posedge clk) begin
    if (rst) begin
      mActive = 0; mK = 0; mDone = 0; mWord = '0; mRail = '0;
    end else if (mActive) begin
      mK = mK + 1;
      mWord = wordAt(mK);
      if (mK >= B6) begin
        mActive = 0;
        mDone = 1;
      end
    end else if (start && !mDone) begin
      mActive = 1;
      mK = 1;
      mRail = 8'hA4;
    end
  end

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  bit cmpOn = 0;

  always @(posedge clk) begin
    #3;
    if (cmpOn) begin
      check(mActive ? wordTag(mK) : (mDone ? "R8" : "R1"), "ctrlWord", int'(ctrlWord), int'(mWord));
      check("R2", "railStb", int'(railStb), int'(mActive && mK == 1));
      check("R2", "railCmd", int'(railCmd), int'(mRail));
      check("R10", "busy", int'(busy), int'(mActive));
      check("R8", "done", int'(done), int'(mDone));
      if (ctrlWord != 9'h000) check("R11", "pll clamp bit8", int'(ctrlWord[8]), 1);
      check("R11", "core reset bit4", int'(ctrlWord[4]), 0);
    end
  end

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst = 1'b1;
    start = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset values
    check("R1", "ctrlWord", int'(ctrlWord), 0);
    check("R1", "railCmd", int'(railCmd), 0);
    check("R1", "busy/done/stb", int'({busy, done, railStb}), 0);
    cmpOn = 1;
    rst = 1'b0;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R2", "railStb after start", int'(railStb), 1);
    check("R2", "railCmd after start", int'(railCmd), 8'hA4);
    repeat (100) @(negedge clk);
    start = 1'b1;            // R10: pulse while busy
    @(negedge clk);
    start = 1'b0;
    repeat (NR) @(negedge clk);
    start = 1'b1;            // R10: pulse during clamp phases
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 20000 && !done; i++) @(negedge clk);
    repeat (5) @(negedge clk);
    check("R8", "final word", int'(ctrlWord), 9'h180);
    check("R8", "busy after done", int'(busy), 0);
    // R9: start while done is set
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    check("R9", "busy on skip", int'(busy), 0);
    check("R9", "railStb on skip", int'(railStb), 0);
    check("R9", "word on skip", int'(ctrlWord), 9'h180);
    check("R9", "done on skip", int'(done), 1);
    repeat (3) @(negedge clk);
    // second cold boot with start held high
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check("R1", "word after reset", int'(ctrlWord), 0);
    check("R1", "done after reset", int'(done), 0);
    rst = 1'b0;
    start = 1'b1;            // R10: level held through busy
    repeat (200) @(negedge clk);
    start = 1'b0;
    repeat (NR) @(negedge clk);
    check("R3", "word mid second run", int'(ctrlWord), 9'h121);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1", "word after mid-run reset", int'(ctrlWord), 0);
    check("R1", "busy after mid-run reset", int'(busy), 0);
    repeat (4) @(negedge clk);
    finish_run();
  end

endmodule